// File: doc/BRIEF.md
# Signalling-Channel Frame Buffer with Access Interrupt

This block carries the low-rate signalling channel between a one-byte processor register and a framed serial stream. Every frame of the stream gives the channel either two bit cells (16 kb/s rate) or one bit cell (8 kb/s rate). A byte written by the processor is sent out over a cycle of four frames (two bits per frame) or eight frames (one bit per frame). In the same cycle the bits that arrive on the receive line are collected into a byte that the processor can read.

Once per cycle, just after the last channel bit of the cycle has been received, the block copies the completed receive byte into its readable register and raises an interrupt. The processor then has until the next frame pulse to read the received byte and to write the next transmit byte. A write goes into a holding register and is moved into the transmit register only at the next cycle boundary. If the processor writes nothing, the same byte is sent again. The serial bit timing comes in as a one-clock bit-cell strobe and a frame-pulse flag on the system clock. The rate is selected by an input. The frame length and the first channel bit cell are parameters.

Top module: `dch_frame_buffer`

## Requirements
- R1: In 16 kb/s mode (`mode_8k`=0), frame k of a cycle (k = 0..3) sends byte bit 2k in cell DCH_CELL and bit 2k+1 in cell DCH_CELL+1. A cycle starts at the first frame pulse after reset and at every fourth frame pulse after that.
- R2: In 8 kb/s mode (`mode_8k`=1), a cycle is eight frames, and frame k (k = 0..7) sends byte bit k in cell DCH_CELL.
- R3: A byte written on `cpu_wr` does not change the byte already being sent. It is sent from the next cycle boundary on.
- R4: When no write occurs during a cycle, the same transmit byte is sent again in the next cycle.
- R5: `rst` and `soft_rst` both set the holding register and the transmit register to 8'hFF, and both drop `irq`.
- R6: `ser_out` is 1 in every bit cell that does not carry the signalling channel.
- R7: Received bits are packed into byte positions in the same frame and cell order as transmit. The completed byte appears on `cpu_rdata` on the same clock edge at which `irq` rises.
- R8: `irq` rises once per cycle, in the last frame of the cycle, at the start of cell DCH_CELL+2 in 16 kb/s mode or cell DCH_CELL+1 in 8 kb/s mode. It is low before that point.
- R9: A `cpu_rd` or `cpu_wr` strobe while `irq` is high drops `irq` on the next clock.
- R10: If no access occurs, `irq` drops at the next frame pulse.
- R11: `cpu_rdata` changes only when the interrupt is raised. Reads and writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset; restarts frame alignment |
| soft_rst | input | 1 | Synchronous software reset of the transmit registers and interrupt |
| mode_8k | input | 1 | 1 = one channel bit per frame, 0 = two bits per frame |
| bit_en | input | 1 | One-clock strobe marking the start of each serial bit cell |
| frame_pulse | input | 1 | With `bit_en`, marks the start of cell 0 of a frame |
| ser_in | input | 1 | Received serial data, sampled at the end of each cell |
| ser_out | output | 1 | Transmitted serial data for the current cell |
| cpu_wr | input | 1 | Write strobe for the channel register |
| cpu_rd | input | 1 | Read strobe for the channel register |
| cpu_wdata | input | 8 | Transmit byte to load |
| cpu_rdata | output | 8 | Last completed receive byte |
| irq | output | 1 | Access-window interrupt, active high |

## Verification
The bench runs both rates with random transmit bytes written at random cells and random receive bytes on `ser_in`. A bit placed in the wrong frame or cell then shows up as a difference in `ser_out` or `cpu_rdata`. Quiet cycles with no writes separate resending the held byte from losing it. Writes in the middle of a cycle separate a byte taken at the cycle boundary from one taken at once. Interrupt windows are closed at random: sometimes by a read, sometimes by a write, and sometimes left for the frame pulse. This tells apart the two clear paths and the set timing. A software reset in the middle of a cycle shows whether the 8'hFF preset reaches the byte that is already on the line.

// File: rtl/dchbuf_pkg.sv
package dchbuf_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = 3;

    typedef enum logic {
        RATE_16K = 1'b0,
        RATE_8K  = 1'b1
    } rate_e;

    // Position of the current bit cell relative to the signalling channel
    typedef struct packed {
        logic                 in_dch;
        logic [BIT_IDX_W-1:0] bit_idx;
    } slot_t;

    // Index of the final frame of a transfer cycle
    function automatic logic [2:0] last_frame(rate_e r);
        return (r == RATE_8K) ? 3'd7 : 3'd3;
    endfunction

    // Byte bit carried by a channel cell: frame index plus cell within pair
    function automatic logic [BIT_IDX_W-1:0] map_bit(rate_e r, logic [2:0] frm, logic second);
        logic [BIT_IDX_W-1:0] idx;
        if (r == RATE_8K) idx = frm;
        else              idx = {frm[1:0], second};
        return idx;
    endfunction

endpackage

// File: rtl/dch_timing.sv
module dch_timing
    import dchbuf_pkg::*;
#(
    parameter int BITS_PER_FRAME = 32,
    parameter int DCH_CELL       = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  rate_e rate,
    input  logic  bit_en,
    input  logic  frame_pulse,
    output slot_t slot,
    output logic  cycle_start,
    output logic  frame_start,
    output logic  byte_done
);

    localparam int CNT_W = (BITS_PER_FRAME > 1) ? $clog2(BITS_PER_FRAME) : 1;
    localparam logic [CNT_W-1:0] CELL_MAX = CNT_W'(BITS_PER_FRAME - 1);
    localparam logic [CNT_W-1:0] CELL_A   = CNT_W'(DCH_CELL);
    localparam logic [CNT_W-1:0] CELL_B   = CNT_W'(DCH_CELL + 1);

    generate
        if (DCH_CELL + 3 > BITS_PER_FRAME) begin : g_bad_cell
            $error("channel cells plus interrupt cell must fit in the frame");
        end
    endgenerate

    logic [CNT_W-1:0] cell_q;
    logic [2:0]       frm_q;
    logic             wrap;

    assign wrap = (frm_q >= last_frame(rate));

    always_ff @(posedge clk) begin
        if (rst) begin
            cell_q <= CELL_MAX;
            frm_q  <= 3'd7;
        end else if (bit_en) begin
            if (frame_pulse) begin
                cell_q <= '0;
                frm_q  <= wrap ? 3'd0 : frm_q + 3'd1;
            end else if (cell_q != CELL_MAX) begin
                cell_q <= cell_q + 1'b1;
            end
        end
    end

    always_comb begin
        slot.in_dch  = (cell_q == CELL_A) || ((rate == RATE_16K) && (cell_q == CELL_B));
        slot.bit_idx = map_bit(rate, frm_q, cell_q == CELL_B);
    end

    assign frame_start = bit_en & frame_pulse;
    assign cycle_start = frame_start & wrap;
    assign byte_done   = bit_en & slot.in_dch & (slot.bit_idx == 3'd7);

endmodule

// File: rtl/dch_tx.sv
module dch_tx
    import dchbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              cycle_start,
    input  slot_t             slot,
    output logic [BYTE_W-1:0] cur_byte,
    output logic              ser_out
);

    logic [BYTE_W-1:0] hold_q;
    logic [BYTE_W-1:0] cur_q;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            hold_q <= '1;
            cur_q  <= '1;
        end else begin
            if (wr_en)       hold_q <= wr_data;
            if (cycle_start) cur_q  <= hold_q;
        end
    end

    assign cur_byte = cur_q;
    assign ser_out  = slot.in_dch ? cur_q[slot.bit_idx] : 1'b1;

endmodule

// File: rtl/dch_rx.sv
module dch_rx
    import dchbuf_pkg::*;
(
    input  logic              clk,
    input  logic              bit_en,
    input  slot_t             slot,
    input  logic              ser_in,
    input  logic              byte_done,
    output logic [BYTE_W-1:0] rd_byte
);

    logic [BYTE_W-1:0] gather_q;
    logic [BYTE_W-1:0] gather_nxt;
    logic [BYTE_W-1:0] rd_q;
    logic              take;

    assign take = bit_en & slot.in_dch;

    generate
        for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
            assign gather_nxt[i] = (take && (slot.bit_idx == BIT_IDX_W'(i))) ? ser_in : gather_q[i];
        end
    endgenerate

    // Receive storage carries no reset preset
    always_ff @(posedge clk) begin
        gather_q <= gather_nxt;
        if (byte_done) rd_q <= gather_nxt;
    end

    assign rd_byte = rd_q;

endmodule

// File: rtl/dch_irq.sv
module dch_irq (
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic set_evt,
    input  logic access,
    input  logic frame_start,
    output logic irq
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst || soft_rst)           irq_q <= 1'b0;
        else if (set_evt)              irq_q <= 1'b1;
        else if (access || frame_start) irq_q <= 1'b0;
    end

    assign irq = irq_q;

endmodule

// File: rtl/dch_frame_buffer.sv
module dch_frame_buffer
    import dchbuf_pkg::*;
#(
    parameter int BITS_PER_FRAME = 32,
    parameter int DCH_CELL       = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       soft_rst,
    input  logic       mode_8k,
    input  logic       bit_en,
    input  logic       frame_pulse,
    input  logic       ser_in,
    output logic       ser_out,
    input  logic       cpu_wr,
    input  logic       cpu_rd,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    output logic       irq
);

    rate_e             rate;
    slot_t             slot;
    logic              cycle_start;
    logic              frame_start;
    logic              byte_done;
    logic [BYTE_W-1:0] tx_cur;

    assign rate = rate_e'(mode_8k);

    dch_timing #(
        .BITS_PER_FRAME(BITS_PER_FRAME),
        .DCH_CELL      (DCH_CELL)
    ) u_timing (
        .clk        (clk),
        .rst        (rst),
        .rate       (rate),
        .bit_en     (bit_en),
        .frame_pulse(frame_pulse),
        .slot       (slot),
        .cycle_start(cycle_start),
        .frame_start(frame_start),
        .byte_done  (byte_done)
    );

    dch_tx u_tx (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (soft_rst),
        .wr_en      (cpu_wr),
        .wr_data    (cpu_wdata),
        .cycle_start(cycle_start),
        .slot       (slot),
        .cur_byte   (tx_cur),
        .ser_out    (ser_out)
    );

    dch_rx u_rx (
        .clk      (clk),
        .bit_en   (bit_en),
        .slot     (slot),
        .ser_in   (ser_in),
        .byte_done(byte_done),
        .rd_byte  (cpu_rdata)
    );

    dch_irq u_irq (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (soft_rst),
        .set_evt    (byte_done),
        .access     (cpu_rd | cpu_wr),
        .frame_start(frame_start),
        .irq        (irq)
    );

endmodule

// File: rtl/dch_frame_buffer_chk.sv
module dch_frame_buffer_chk
    import dchbuf_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       soft_rst,
    input logic       cpu_rd,
    input logic       cpu_wr,
    input logic       irq,
    input logic       ser_out,
    input logic [7:0] cpu_rdata,
    input slot_t      slot,
    input logic       cycle_start,
    input logic       frame_start,
    input logic       byte_done,
    input logic [7:0] tx_cur
);

    assert_tx_held_R3: assert property (@(posedge clk) disable iff (rst)
        (!cycle_start && !soft_rst) |=> $stable(tx_cur));

    assert_soft_preset_R5: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (tx_cur == 8'hFF) && !irq);

    assert_idle_high_R6: assert property (@(posedge clk) disable iff (rst)
        !slot.in_dch |-> ser_out);

    assert_irq_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(byte_done));

    assert_access_clear_R9: assert property (@(posedge clk) disable iff (rst)
        ((cpu_rd || cpu_wr) && !byte_done) |=> !irq);

    assert_frame_clear_R10: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !irq);

    assert_rdata_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !byte_done |=> $stable(cpu_rdata));

endmodule

bind dch_frame_buffer dch_frame_buffer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (soft_rst),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .irq        (irq),
    .ser_out    (ser_out),
    .cpu_rdata  (cpu_rdata),
    .slot       (slot),
    .cycle_start(cycle_start),
    .frame_start(frame_start),
    .byte_done  (byte_done),
    .tx_cur     (tx_cur)
);

// File: tb/dch_frame_buffer_tb_top.sv
module dch_frame_buffer_tb_top;

    localparam int BPF = 8;
    localparam int DC  = 1;
    localparam int CELL_CLKS = 4;

    logic       clk = 1'b0;
    logic       rst, soft_rst, mode_8k, bit_en, frame_pulse, ser_in;
    logic       cpu_wr, cpu_rd;
    logic [7:0] cpu_wdata;
    logic       ser_out, irq;
    logic [7:0] cpu_rdata;

    always #5 clk = ~clk;

    dch_frame_buffer #(
        .BITS_PER_FRAME(BPF),
        .DCH_CELL      (DC)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (soft_rst),
        .mode_8k    (mode_8k),
        .bit_en     (bit_en),
        .frame_pulse(frame_pulse),
        .ser_in     (ser_in),
        .ser_out    (ser_out),
        .cpu_wr     (cpu_wr),
        .cpu_rd     (cpu_rd),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .irq        (irq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    logic [7:0] m_hold, m_cur, m_rd, rx_byte;
    bit         m_irq, m_rd_ok, synced, wrote;
    int         fr;
    string      tx_tag;

    function automatic int n_frames(bit m8);
        return m8 ? 8 : 4;
    endfunction

    function automatic bit is_dcell(bit m8, int c);
        return (c == DC) || (!m8 && c == DC + 1);
    endfunction

    function automatic int bit_pos(bit m8, int f, int c);
        return m8 ? f : 2 * f + (c - DC);
    endfunction

    function automatic logic exp_ser(bit m8, bit sy, int f, int c, logic [7:0] b);
        if (!sy || !is_dcell(m8, c)) return 1'b1;
        return b[bit_pos(m8, f, c)];
    endfunction

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic do_reset(bit m8);
        @(negedge clk);
        mode_8k = m8; rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R5", "irq in reset", {7'd0, irq}, 8'd0);
        check("R6", "ser_out in reset", {7'd0, ser_out}, 8'd1);
        rst = 1'b0;
        m_hold = 8'hFF; m_cur = 8'hFF; m_irq = 0; synced = 0; wrote = 0;
        fr = n_frames(m8) - 1;
        tx_tag = "R5";
    endtask

    task automatic pad(input int used);
        for (int k = used; k < CELL_CLKS; k++) @(negedge clk);
    endtask

    // one bit cell: strobe, model the edge, drive receive bit, check, optional access
    task automatic run_cell(input int c, input bit acc_en);
        int    used;
        string base;
        bit    m8;
        m8 = mode_8k;
        base = m8 ? "R2" : "R1";
        @(negedge clk);
        bit_en = 1'b1; frame_pulse = (c == 0);
        @(negedge clk);
        bit_en = 1'b0; frame_pulse = 1'b0;
        used = 2;
        if (c == 0) begin
            m_irq = 0;
            synced = 1;
            fr = (fr + 1) % n_frames(m8);
            if (fr == 0) begin
                m_cur = m_hold;
                rx_byte = 8'($urandom);
                tx_tag = wrote ? base : "R4";
                wrote = 0;
            end
        end
        if (synced && fr == n_frames(m8) - 1 && c == DC + (m8 ? 1 : 2)) begin
            m_irq = 1; m_rd = rx_byte; m_rd_ok = 1;
        end
        ser_in = (synced && is_dcell(m8, c)) ? rx_byte[bit_pos(m8, fr, c)] : 1'($urandom);
        check(is_dcell(m8, c) ? tx_tag : "R6", "ser_out",
              {7'd0, ser_out}, {7'd0, exp_ser(m8, synced, fr, c, m_cur)});
        check((c == 0) ? "R10" : "R8", "irq", {7'd0, irq}, {7'd0, m_irq});
        if (m_rd_ok) check("R7", "cpu_rdata", cpu_rdata, m_rd);
        if (acc_en) begin
            if (m_irq && ($urandom % 3) != 0) begin
                if ($urandom % 2) begin
                    cpu_rd = 1'b1;
                end else begin
                    cpu_wr = 1'b1; cpu_wdata = 8'($urandom);
                    m_hold = cpu_wdata; wrote = 1;
                end
                @(negedge clk);
                cpu_rd = 1'b0; cpu_wr = 1'b0; used++;
                m_irq = 0;
                check("R9", "irq after access", {7'd0, irq}, 8'd0);
                if (m_rd_ok) check("R11", "cpu_rdata after access", cpu_rdata, m_rd);
            end else if (($urandom % 14) == 0) begin
                cpu_wr = 1'b1; cpu_wdata = 8'($urandom);
                @(negedge clk);
                cpu_wr = 1'b0; used++;
                m_hold = cpu_wdata; wrote = 1; m_irq = 0;
                if (fr != n_frames(m8) - 1 || c < DC + (m8 ? 1 : 2)) tx_tag = "R3";
                check("R3", "ser_out after mid-cycle write",
                      {7'd0, ser_out}, {7'd0, exp_ser(m8, synced, fr, c, m_cur)});
            end
        end
        pad(used);
    endtask

    task automatic soft_reset_now();
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        m_hold = 8'hFF; m_cur = 8'hFF; m_irq = 0; wrote = 0;
        tx_tag = "R5";
        check("R5", "irq after soft reset", {7'd0, irq}, 8'd0);
    endtask

    task automatic run_cycles(input int n, input bit acc_en, input int soft_at);
        int nf;
        nf = n_frames(mode_8k);
        for (int cy = 0; cy < n; cy++)
            for (int f = 0; f < nf; f++)
                for (int c = 0; c < BPF; c++) begin
                    run_cell(c, acc_en);
                    if (soft_at >= 0 && cy == 0 && f * BPF + c == soft_at) soft_reset_now();
                end
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; soft_rst = 1'b0; mode_8k = 1'b0; bit_en = 1'b0; frame_pulse = 1'b0;
        ser_in = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_wdata = 8'h00;
        m_rd_ok = 0; m_rd = 8'h00; rx_byte = 8'h00;

        // 16 kb/s: quiet cycles resend the preset, then random traffic
        do_reset(1'b0);
        run_cycles(2, 1'b0, -1);
        run_cycles(8, 1'b1, -1);
        run_cycles(1, 1'b0, -1);
        // soft reset in the middle of a cycle
        run_cycles(1, 1'b1, 2 * BPF + 3);
        run_cycles(2, 1'b1, -1);

        // 8 kb/s after a power-up reset
        do_reset(1'b1);
        run_cycles(1, 1'b0, -1);
        run_cycles(6, 1'b1, -1);
        run_cycles(1, 1'b0, -1);

        finish_run();
    end

endmodule